// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one message on a single open-drain consumer-electronics control line. A host fills a small byte buffer, presents the number of bytes (1 to 16) and pulses a send strobe. The transmitter first waits until the line has stayed released for a fixed idle span. It then drives a long start pulse, and after that every byte as eight data bits (most significant first), an end-of-message bit and an acknowledge slot. Each bit is coded by how long the line is held low inside a fixed bit period. The bytes leave exactly as stored; the first byte's low nibble is taken as the destination address only to choose the acknowledge sense.

All timing is counted on a tick enable that pulses once per 0.1 ms. In the acknowledge slot the transmitter drives a short low pulse, which is a logical one, and releases the line. It then checks whether a follower has stretched the pulse. For a directed frame a missing stretch ends the frame with an acknowledge error. For the broadcast destination (nibble 0xF) a stretch is a rejection and ends the frame the same way. A watchdog ends the frame when the line stays low without being driven for too long.

Top module: `cec_frame_tx`

## Requirements
- R1: After reset, pullLow, busy, done, ackErr and timedOut are all 0.
- R2: A sendReq pulse is accepted only while busy is 0 and byteCount is between 1 and 16. A count of 0 or above 16, and any pulse while busy, is ignored: busy and pullLow stay 0, or the running frame goes on unchanged.
- R3: After acceptance and before the start pulse, the line (lineIn=1 means released) must be seen high on 168 consecutive ticks, which is seven 24-tick bit periods. A tick with the line low restarts this count. The start pulse begins in the cycle after the 168th high tick.
- R4: The start pulse holds pullLow for 37 ticks in a period of 45 ticks.
- R5: The bytes are sent in buffer order from address 0, each one unchanged and most significant bit first. The buffer is read through rdAddr/rdData. A 0 is low for 15 ticks and a 1 is low for 6 ticks, each in a 24-tick period.
- R6: After the eight data bits of each byte comes an end-of-message bit, which is 1 only for the last byte. It is followed by an acknowledge slot that the transmitter drives as a 1: low for 6 ticks, then released.
- R7: The line is sampled after 10 ticks of the acknowledge slot. If byte 0 bits [3:0] differ from 0xF, a high sample is a failure. If they equal 0xF, a low sample is a failure. A failure ends the frame at the end of that slot with ackErr=1; no further byte is sent.
- R8: If the line is low while the transmitter does not pull it for 16 consecutive ticks during the start or bit periods, the frame ends at once with timedOut=1 and the line released.
- R9: done is a single-cycle pulse at the end of each frame, whether it ends normally or is aborted. busy is 1 from acceptance until the cycle done rises, and ackErr and timedOut are cleared when the next frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle pulse per 0.1 ms time step |
| sendReq | input | 1 | Start-frame strobe |
| byteCount | input | 5 | Number of bytes in the frame (1 to 16) |
| rdAddr | output | 4 | Buffer read address |
| rdData | input | 8 | Buffer byte at rdAddr (combinational read) |
| lineIn | input | 1 | Sensed line level, 1 = released high |
| pullLow | output | 1 | 1 = drive the open-drain line low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| ackErr | output | 1 | Last frame ended on a failed acknowledge |
| timedOut | output | 1 | Last frame was ended by the watchdog |

## Verification
Faults in this block appear almost entirely as pulse widths and periods on pullLow. A wrong tick count or a stale bit value shows up as a low pulse or a falling-edge spacing that is off by at least one tick, within the bit where it happens. A wrong byte address or shift order corrupts the decoded bytes at the next byte boundary. Faults in the acknowledge sense or the watchdog decide how many bytes leave before done, which makes the byte count and the error flags at done a sharp observable.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FREE,
    ST_START,
    ST_BIT
  } txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFrame;  // latch count, reset address and bit position
    logic loadByte;   // fetch byte 0 into the shifter
    logic advance;    // step to the next bit (and byte)
  } txCtrl_t;

  // datapath status back to control
  typedef struct packed {
    logic txBit;      // logical value of the current bit
    logic ackSlot;    // current bit is the acknowledge slot
    logic lastByte;   // current byte is the final one
    logic bcast;      // destination nibble of byte 0 is broadcast
  } txStat_t;

endpackage

// File: rtl/cec_tx_datapath.sv
module cec_tx_datapath
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1),
  parameter int ADDR_W    = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtrl_t           ctrl,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [BYTE_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output txStat_t           stat
);

  localparam int POS_EOM = BYTE_W;
  localparam int POS_ACK = BYTE_W + 1;
  localparam int POS_W   = $clog2(POS_ACK + 1);

  logic [ADDR_W-1:0] byteAddr;
  logic [ADDR_W-1:0] lastIdx;
  logic [POS_W-1:0]  bitPos;
  logic [BYTE_W-1:0] shiftReg;
  logic              bcastReg;
  logic              inAck;

  assign inAck = (bitPos == POS_W'(POS_ACK));
  // during the acknowledge slot the next byte is already presented
  assign rdAddr = inAck ? byteAddr + ADDR_W'(1) : byteAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteAddr <= '0;
      lastIdx  <= '0;
      bitPos   <= '0;
      shiftReg <= '0;
      bcastReg <= 1'b0;
    end else begin
      if (ctrl.loadFrame) begin
        byteAddr <= '0;
        lastIdx  <= ADDR_W'(byteCount - CNT_W'(1));
        bitPos   <= '0;
      end
      if (ctrl.loadByte) begin
        shiftReg <= rdData;
        bcastReg <= (rdData[3:0] == 4'hF);
      end
      if (ctrl.advance) begin
        if (inAck) begin
          bitPos   <= '0;
          byteAddr <= byteAddr + ADDR_W'(1);
          shiftReg <= rdData;
        end else begin
          bitPos <= bitPos + POS_W'(1);
          if (bitPos < POS_W'(POS_EOM)) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_comb begin
    stat.lastByte = (byteAddr == lastIdx);
    stat.ackSlot  = inAck;
    stat.bcast    = bcastReg;
    if (bitPos < POS_W'(POS_EOM))       stat.txBit = shiftReg[BYTE_W-1];
    else if (bitPos == POS_W'(POS_EOM)) stat.txBit = stat.lastByte;
    else                                stat.txBit = 1'b1;
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.loadFrame, ctrl.loadByte, ctrl.advance}));

  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteAddr <= lastIdx);

endmodule

// File: rtl/cec_tx_control.sv
module cec_tx_control
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES      = 16,
  parameter int CNT_W          = $clog2(MAX_BYTES + 1),
  parameter int START_LOW      = 37,
  parameter int START_PERIOD   = 45,
  parameter int ZERO_LOW       = 15,
  parameter int ONE_LOW        = 6,
  parameter int BIT_PERIOD     = 24,
  parameter int SAMPLE_TICKS   = 10,
  parameter int FREE_BITS      = 7,
  parameter int WATCHDOG_TICKS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             sendReq,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             lineIn,
  input  txStat_t          stat,
  output txCtrl_t          ctrl,
  output logic             pullLow,
  output logic             busy,
  output logic             done,
  output logic             ackErr,
  output logic             timedOut
);

  localparam int TW         = $clog2(START_PERIOD + 1);
  localparam int FREE_TICKS = FREE_BITS * BIT_PERIOD;
  localparam int FW         = $clog2(FREE_TICKS + 1);
  localparam int WW         = $clog2(WATCHDOG_TICKS + 1);

  txState_t      state;
  logic [TW-1:0] tickCnt;
  logic [TW-1:0] lowWidth;
  logic [TW-1:0] periodLen;
  logic [FW-1:0] freeCnt;
  logic [WW-1:0] wdCnt;
  logic          ackHigh;
  logic          accept, inBit, periodEnd, wdFire, freeDone, sampleNow, ackBad, frameEnd;

  always_comb begin
    inBit     = (state == ST_START) || (state == ST_BIT);
    lowWidth  = (state == ST_START) ? TW'(START_LOW)
              : (stat.txBit ? TW'(ONE_LOW) : TW'(ZERO_LOW));
    periodLen = (state == ST_START) ? TW'(START_PERIOD) : TW'(BIT_PERIOD);
    pullLow   = inBit && (tickCnt < lowWidth);
    periodEnd = inBit && tickEn && (tickCnt == periodLen - TW'(1));
    wdFire    = inBit && tickEn && !lineIn && !pullLow
              && (wdCnt == WW'(WATCHDOG_TICKS - 1));
    accept    = (state == ST_IDLE) && sendReq && (byteCount != '0)
              && (byteCount <= CNT_W'(MAX_BYTES));
    freeDone  = (state == ST_FREE) && lineIn && tickEn
              && (freeCnt == FW'(FREE_TICKS - 1));
    sampleNow = (state == ST_BIT) && stat.ackSlot && tickEn
              && (tickCnt == TW'(SAMPLE_TICKS - 1));
    ackBad    = stat.bcast ? !ackHigh : ackHigh;
    frameEnd  = (state == ST_BIT) && periodEnd && stat.ackSlot && !wdFire
              && (ackBad || stat.lastByte);
    ctrl.loadFrame = accept;
    ctrl.loadByte  = freeDone;
    ctrl.advance   = (state == ST_BIT) && periodEnd && !wdFire && !frameEnd;
    busy           = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      tickCnt  <= '0;
      freeCnt  <= '0;
      wdCnt    <= '0;
      ackHigh  <= 1'b0;
      done     <= 1'b0;
      ackErr   <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sampleNow) ackHigh <= lineIn;
      if (inBit) begin
        if (lineIn || pullLow) wdCnt <= '0;
        else if (tickEn)       wdCnt <= wdCnt + WW'(1);
      end
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_FREE;
            freeCnt  <= '0;
            ackErr   <= 1'b0;
            timedOut <= 1'b0;
          end
        end
        ST_FREE: begin
          if (!lineIn) begin
            freeCnt <= '0;
          end else if (freeDone) begin
            state   <= ST_START;
            tickCnt <= '0;
            wdCnt   <= '0;
          end else if (tickEn) begin
            freeCnt <= freeCnt + FW'(1);
          end
        end
        default: begin
          if (wdFire) begin
            state    <= ST_IDLE;
            timedOut <= 1'b1;
            done     <= 1'b1;
          end else if (frameEnd) begin
            state  <= ST_IDLE;
            ackErr <= ackBad;
            done   <= 1'b1;
          end else if (periodEnd) begin
            state   <= ST_BIT;
            tickCnt <= '0;
          end else if (tickEn) begin
            tickCnt <= tickCnt + TW'(1);
          end
        end
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  ackerr_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackErr) |-> (done && !busy));

  // R8
  to_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> (!busy && !pullLow));

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BIT && stat.ackSlot && tickCnt >= TW'(SAMPLE_TICKS)) |-> !pullLow);

endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int MAX_BYTES      = 16,
  parameter int START_LOW      = 37,
  parameter int START_PERIOD   = 45,
  parameter int ZERO_LOW       = 15,
  parameter int ONE_LOW        = 6,
  parameter int BIT_PERIOD     = 24,
  parameter int SAMPLE_TICKS   = 10,
  parameter int FREE_BITS      = 7,
  parameter int WATCHDOG_TICKS = 16,
  localparam int CNT_W         = $clog2(MAX_BYTES + 1),
  localparam int ADDR_W        = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              sendReq,
  input  logic [CNT_W-1:0]  byteCount,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  input  logic              lineIn,
  output logic              pullLow,
  output logic              busy,
  output logic              done,
  output logic              ackErr,
  output logic              timedOut
);

  txCtrl_t ctrl;
  txStat_t stat;

  cec_tx_control #(
    .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W),
    .START_LOW(START_LOW), .START_PERIOD(START_PERIOD),
    .ZERO_LOW(ZERO_LOW), .ONE_LOW(ONE_LOW), .BIT_PERIOD(BIT_PERIOD),
    .SAMPLE_TICKS(SAMPLE_TICKS), .FREE_BITS(FREE_BITS),
    .WATCHDOG_TICKS(WATCHDOG_TICKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sendReq(sendReq),
    .byteCount(byteCount), .lineIn(lineIn), .stat(stat), .ctrl(ctrl),
    .pullLow(pullLow), .busy(busy), .done(done), .ackErr(ackErr),
    .timedOut(timedOut)
  );

  cec_tx_datapath #(
    .MAX_BYTES(MAX_BYTES), .BYTE_W(8), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .byteCount(byteCount),
    .rdData(rdData), .rdAddr(rdAddr), .stat(stat)
  );

endmodule

// File: tb/sim_cec_frame_tx.sv
`timescale 1ns/1ps
module sim_cec_frame_tx;

  logic clk = 0, rstN = 0, tickEn = 0, sendReq = 0;
  logic [4:0] byteCount = '0;
  logic [3:0] rdAddr;
  logic [7:0] rdData;
  logic lineIn, pullLow, busy, done, ackErr, timedOut;
  logic benchHold = 0;
  int   followCnt = 0;

  logic [7:0] mem [16];
  bit   ackMask [16];
  int   followLen = 15;

  always #5 clk = ~clk;

  int tickDiv = 0;
  always @(posedge clk) begin
    tickDiv <= (tickDiv == 3) ? 0 : tickDiv + 1;
    tickEn  <= (tickDiv == 3);
  end

  assign rdData = mem[rdAddr];
  assign lineIn = !(pullLow || benchHold || followCnt != 0);

  cec_frame_tx u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sendReq(sendReq),
    .byteCount(byteCount), .rdAddr(rdAddr), .rdData(rdData), .lineIn(lineIn),
    .pullLow(pullLow), .busy(busy), .done(done), .ackErr(ackErr),
    .timedOut(timedOut)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expEom(input int i, input int len);
    return i == len - 1;
  endfunction

  // line monitor / decoder / follower
  bit   prevLine = 1, inFrame = 0, prevWasStart = 0, pullSeen = 0, donePrev = 0;
  int   lowTicks = 0, periodTicks = 0, bitInByte = 0, byteIdx = 0, startLow = 0;
  int   widthBad = 0, periodBad = 0, freeTicks = 0, doneCnt = 0, doneBad = 0;
  logic [7:0] curByte = 0;
  logic [7:0] rxByte [16];
  bit   rxEom [16];

  always @(negedge clk) if (rstN) begin
    if (followCnt != 0 && tickEn) followCnt--;
    if (done) begin doneCnt++; if (donePrev) doneBad++; end
    donePrev = done;
    if (busy && !pullSeen) begin
      if (pullLow) pullSeen = 1;
      else if (tickEn) freeTicks++;
    end
    if (prevLine && !lineIn) begin
      if (inFrame) begin
        if (periodTicks != (prevWasStart ? 45 : 24)) periodBad++;
        prevWasStart = 0;
        if (bitInByte == 9 && byteIdx < 16 && ackMask[byteIdx]) followCnt = followLen;
      end
      periodTicks = tickEn;
      lowTicks = tickEn;
    end else begin
      if (tickEn) periodTicks++;
      if (!lineIn && tickEn) lowTicks++;
    end
    if (!prevLine && lineIn) begin
      if (lowTicks >= 30 && lowTicks <= 40) begin
        inFrame = 1; prevWasStart = 1; startLow = lowTicks; byteIdx = 0; bitInByte = 0;
      end else if (inFrame && byteIdx < 16) begin
        if (bitInByte < 9 && lowTicks != 6 && lowTicks != 15) widthBad++;
        if (bitInByte < 8) curByte = {curByte[6:0], lowTicks <= 10};
        else if (bitInByte == 8) rxEom[byteIdx] = (lowTicks <= 10);
        else begin
          if (!ackMask[byteIdx] && lowTicks != 6) widthBad++;
          rxByte[byteIdx] = curByte;
          byteIdx++;
        end
        bitInByte = (bitInByte == 9) ? 0 : bitInByte + 1;
      end
    end
    prevLine = lineIn;
  end

  task automatic waitTicks(input int n);
    int seen = 0;
    while (seen < n) begin @(negedge clk); if (tickEn) seen++; end
  endtask

  task automatic frameReset();
    inFrame = 0; byteIdx = 0; bitInByte = 0; widthBad = 0; periodBad = 0;
    freeTicks = 0; pullSeen = 0; doneCnt = 0; doneBad = 0; startLow = 0;
    for (int i = 0; i < 16; i++) begin rxByte[i] = 8'hxx; rxEom[i] = 0; end
  endtask

  task automatic runFrame(input int len, input bit expAe, input bit expTo,
                          input int expBytes, input bit checkFree);
    frameReset();
    @(negedge clk); byteCount = 5'(len); sendReq = 1;
    @(negedge clk); sendReq = 0;
    check(busy == 1, "R2 accepted", busy, 1);
    while (doneCnt == 0) @(negedge clk);
    waitTicks(60);
    check(busy == 0 && !pullLow, "R9 idle after done", busy, 0);
    check(doneCnt == 1 && doneBad == 0, "R9 done single pulse", doneCnt, 1);
    check(ackErr == expAe, "R7 ackErr", ackErr, expAe);
    check(timedOut == expTo, "R8 timedOut", timedOut, expTo);
    check(byteIdx == expBytes, "R7 bytes sent", byteIdx, expBytes);
    check(startLow == 37, "R4 start low ticks", startLow, 37);
    check(periodBad == 0, "R4 R5 bit periods", periodBad, 0);
    check(widthBad == 0, "R5 R6 low widths", widthBad, 0);
    for (int i = 0; i < expBytes; i++) begin
      check(rxByte[i] == mem[i], "R5 byte value", rxByte[i], mem[i]);
      check(rxEom[i] == expEom(i, len), "R6 eom bit", rxEom[i], expEom(i, len));
    end
    if (checkFree) check(freeTicks == 168, "R3 idle span", freeTicks, 168);
  endtask

  task automatic fillRandom(input int len);
    for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
    if (mem[0][3:0] == 4'hF) mem[0][3:0] = 4'hE;
  endtask

  task automatic setMask(input bit v);
    for (int i = 0; i < 16; i++) ackMask[i] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedInit, n;
    seedInit = $urandom(32'h1234);
    setMask(1);
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check(!pullLow, "R1 pullLow", pullLow, 0);
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(!ackErr && !timedOut, "R1 flags", {ackErr, timedOut}, 0);

    // R2 out-of-range counts ignored
    byteCount = 0; sendReq = 1; @(negedge clk); sendReq = 0;
    waitTicks(20);
    check(!busy && !pullLow, "R2 count 0 ignored", busy, 0);
    byteCount = 17; sendReq = 1; @(negedge clk); sendReq = 0;
    waitTicks(20);
    check(!busy && !pullLow, "R2 count 17 ignored", busy, 0);

    // directed frames
    mem[0] = 8'h04;
    runFrame(1, 0, 0, 1, 1);
    mem[0] = 8'h40; mem[1] = 8'h5A;
    runFrame(2, 0, 0, 2, 1);

    // random frames
    for (int k = 0; k < 4; k++) begin
      int len;
      len = 1 + int'($urandom % 16);
      fillRandom(len);
      runFrame(len, 0, 0, len, 1);
    end

    // full length frame with a strobe while busy (R2)
    fillRandom(16);
    fork
      runFrame(16, 0, 0, 16, 1);
      begin
        waitTicks(400);
        byteCount = 3; sendReq = 1; @(negedge clk); sendReq = 0;
      end
    join
    waitTicks(200);
    check(!busy && !pullLow, "R2 strobe while busy ignored", busy, 0);

    // R7 directed frame, no acknowledge on byte 2
    mem[0] = 8'h41; mem[1] = 8'h82; mem[2] = 8'h33; mem[3] = 8'h10;
    setMask(1); ackMask[2] = 0;
    runFrame(4, 1, 0, 3, 1);

    // R7 broadcast, nobody rejects
    mem[0] = 8'h4F; mem[1] = 8'h36; mem[2] = 8'h00;
    setMask(0);
    runFrame(3, 0, 0, 3, 1);
    // R7 broadcast, rejection on byte 1
    ackMask[1] = 1;
    runFrame(3, 1, 0, 2, 1);

    // R3 idle span restarts on a low tick
    setMask(1);
    mem[0] = 8'h04; mem[1] = 8'hC3;
    benchHold = 1;
    fork
      runFrame(2, 0, 0, 2, 0);
      begin
        waitTicks(50); benchHold = 0;
        waitTicks(100); benchHold = 1;
        waitTicks(5); benchHold = 0;
        n = tickEn ? 1 : 0;
        forever begin
          @(negedge clk);
          if (pullLow) break;
          if (tickEn) n++;
        end
        check(n == 168, "R3 span after low glitch", n, 168);
      end
    join

    // R8 follower holds the line far too long in the first acknowledge slot
    mem[0] = 8'h04; mem[1] = 8'h99;
    followLen = 45;
    runFrame(2, 0, 1, 1, 1);
    followLen = 15;

    // R9 flags cleared by the next accepted frame
    mem[0] = 8'h05;
    runFrame(1, 0, 0, 1, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule